// File: doc/BRIEF.md
# Receive Descriptor Availability Tracker

This block sits beside a DMA receive channel and keeps the number of receive descriptors that software has handed to the channel. Software adds descriptors by writing a quantity to the count register. The channel returns one pulse for each descriptor it fills, and the block takes one descriptor off the count for each pulse. A low-watermark output compares the available count with a programmable threshold. This output is recomputed every cycle and never latched, so it can rise and then fall again when a count write overlaps with consumption.

For each packet, the block decides whether incoming data beats may be stored:

- **No descriptors at packet start.** The whole packet is dropped, a one-cycle drop interrupt is raised, and a saturating lost-packet counter advances. Any write to that counter zeroes it.
- **Descriptors run out partway through a packet.** The remaining beats of that packet are discarded. The receive status records an error flag and the number of bytes stored before the failure.
- **Recovery.** Reception restarts only at the next packet start that finds descriptors available. A count write made during a discarded packet does not revive that packet.

Data movement itself is outside this block. It only produces the per-beat store decision and the status seen by software.

Top module: `rx_dscr_tracker`

## Requirements
- R1: After reset the available count, threshold, lost-packet counter and receive status all read 0, and `watermarkLow`, `pktDropIrq` and `beatStore` are low.
- R2: A write to register address 0 adds `wrData` to the available count, which saturates at 0xFFFF instead of wrapping. Register address 0 reads back the available count.
- R3: A `dscrUsed` pulse lowers the available count by one, and has no effect when the count is 0. A count write and a `dscrUsed` pulse in the same cycle give old + written − 1, saturated at 0xFFFF.
- R4: `watermarkLow` is high exactly when the available count is strictly less than the threshold, which is read and written at register address 1. The output follows every count change with no sticky state.
- R5: A `pktStart` seen while the available count is 0 drops the whole packet. `pktDropIrq` is high for the one cycle after that start, and no beat of the packet is stored.
- R6: Register address 2 reads the lost-packet counter. This counter counts packets dropped at start and saturates at 0xFFFF. Any write to address 2 zeroes it regardless of data. If a clearing write and a drop fall in the same cycle, the result is 1.
- R7: A beat arriving inside a packet while the available count is 0 is not stored, and neither is any later beat of that packet. The receive status becomes bit 15 = 1 with bits 14:0 = bytes stored in that packet before the failing beat.
- R8: A packet that ends without error sets the receive status to bit 15 = 0 with bits 14:0 = total bytes stored, counting a beat that arrives in the same cycle as `pktEnd`. Beats are counted from the cycle after `pktStart` up to and including the `pktEnd` cycle.
- R9: After a drop or a mid-packet error, beats stay discarded until `pktEnd`, even if descriptors are added meanwhile. Reception resumes at the next `pktStart` that sees a non-zero count.
- R10: `beatStore` is high only for a beat inside an accepted packet while the count is non-zero. It is low for beats outside any packet.
- R11: Register address 3 reads the receive status. Writes to address 3 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register write address |
| wrData | input | 16 | Register write data |
| rdAddr | input | 2 | Register read address |
| rdData | output | 16 | Register read data (combinational) |
| pktStart | input | 1 | Packet start strobe |
| pktEnd | input | 1 | Packet end strobe |
| beatValid | input | 1 | A data beat is offered |
| beatBytes | input | 4 | Bytes carried by the beat |
| dscrUsed | input | 1 | One descriptor was consumed |
| beatStore | output | 1 | The offered beat may be stored |
| watermarkLow | output | 1 | Available count below threshold |
| pktDropIrq | output | 1 | One-cycle pulse for a packet dropped at start |

## Verification
The bench targets these corner cases:

- **Write and consume in the same cycle.** A design that let one event win would read 6 or 1 instead of 5.
- **Consume at zero.** A design that wrapped would read 0xFFFF.
- **Descriptors exhausted mid-packet.** A design that latched the wrong byte total, or kept storing beats after a count write during the discard, would show a wrong status or a high `beatStore`.
- **Watermark clearing.** The watermark must fall again once the count recovers, which a sticky flag would not do.
- **Clearing the lost-packet counter as a drop lands.** A design that let the clear win would read 0 instead of 1.
- **Count saturation.** A design that wrapped would read a small value instead of 0xFFFF.

// File: rtl/rdt_pkg.sv
package rdt_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_RECV    = 2'd1,
    ST_DISCARD = 2'd2,
    ST_DROP    = 2'd3
  } rxState_t;

  // Strobes from the control FSM into the datapath.
  typedef struct packed {
    logic clearBytes;
    logic addBeat;
    logic latchOk;
    logic latchErr;
    logic countDrop;
  } ctrlStrobe_t;

  localparam logic [1:0] ADDR_COUNT  = 2'd0;
  localparam logic [1:0] ADDR_THRESH = 2'd1;
  localparam logic [1:0] ADDR_DROP   = 2'd2;
  localparam logic [1:0] ADDR_STATUS = 2'd3;

endpackage

// File: rtl/rdt_datapath.sv
module rdt_datapath
  import rdt_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BEAT_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [1:0]        rdAddr,
  output logic [DATA_W-1:0] rdData,
  input  logic [BEAT_W-1:0] beatBytes,
  input  logic              dscrUsed,
  output logic              availZero,
  output logic              watermarkLow
);

  localparam int BYTE_W = DATA_W - 1;

  logic [DATA_W-1:0] availCnt, availNext;
  logic [DATA_W-1:0] threshReg;
  logic [DATA_W-1:0] dropCnt, dropNext;
  logic [BYTE_W-1:0] byteCnt, byteNext;
  logic [BYTE_W-1:0] statBytes;
  logic              statErr;

  logic              cntWr, threshWr, dropClr;
  logic [DATA_W:0]   availSum;
  logic [BYTE_W:0]   byteSum;
  logic [DATA_W-1:0] dropBase;

  assign cntWr    = wrEn && (wrAddr == ADDR_COUNT);
  assign threshWr = wrEn && (wrAddr == ADDR_THRESH);
  assign dropClr  = wrEn && (wrAddr == ADDR_DROP);

  // Available count: add, then consume, then saturate.
  always_comb begin
    availSum = {1'b0, availCnt} + (cntWr ? {1'b0, wrData} : '0);
    if (dscrUsed && (availSum != '0)) availSum = availSum - 1'b1;
    availNext = availSum[DATA_W] ? '1 : availSum[DATA_W-1:0];
  end

  // Byte total of the current packet, saturating.
  always_comb begin
    byteSum = {1'b0, byteCnt};
    if (strobe.addBeat)
      byteSum = byteSum + {{(BYTE_W + 1 - BEAT_W){1'b0}}, beatBytes};
    byteNext = byteSum[BYTE_W] ? '1 : byteSum[BYTE_W-1:0];
  end

  // Lost-packet counter: a clear and a drop together give one.
  always_comb begin
    dropBase = dropClr ? '0 : dropCnt;
    dropNext = dropBase;
    if (strobe.countDrop && (dropBase != '1)) dropNext = dropBase + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      availCnt  <= '0;
      threshReg <= '0;
      dropCnt   <= '0;
      byteCnt   <= '0;
      statBytes <= '0;
      statErr   <= 1'b0;
    end else begin
      availCnt <= availNext;
      dropCnt  <= dropNext;
      if (threshWr) threshReg <= wrData;
      byteCnt <= strobe.clearBytes ? '0 : byteNext;
      if (strobe.latchErr) begin
        statErr   <= 1'b1;
        statBytes <= byteCnt;
      end else if (strobe.latchOk) begin
        statErr   <= 1'b0;
        statBytes <= byteNext;
      end
    end
  end

  assign availZero    = (availCnt == '0);
  assign watermarkLow = (availCnt < threshReg);

  always_comb begin
    unique case (rdAddr)
      ADDR_COUNT:  rdData = availCnt;
      ADDR_THRESH: rdData = threshReg;
      ADDR_DROP:   rdData = dropCnt;
      default:     rdData = {statErr, statBytes};
    endcase
  end

  // R2: a count write alone never lowers the count.
  p_sat_add_r2: assert property (@(posedge clk) disable iff (!rstN)
    (cntWr && !dscrUsed) |=> (availCnt >= $past(availCnt)));

  // R3: a lone consumption takes exactly one off a non-zero count.
  p_consume_r3: assert property (@(posedge clk) disable iff (!rstN)
    (dscrUsed && !cntWr && !availZero) |=> (availCnt == $past(availCnt) - 1'b1));

  // R3: consumption at zero leaves zero.
  p_zero_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (dscrUsed && !cntWr && availZero) |=> availZero);

  // R6: a clearing write with no drop leaves the counter at zero.
  p_drop_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    (dropClr && !strobe.countDrop) |=> (dropCnt == '0));

  // R7: an error latch marks the status.
  p_err_flag_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.latchErr |=> statErr);

endmodule

// File: rtl/rdt_control.sv
module rdt_control
  import rdt_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        pktStart,
  input  logic        pktEnd,
  input  logic        beatValid,
  input  logic        availZero,
  output ctrlStrobe_t strobe,
  output logic        beatStore,
  output logic        pktDropIrq,
  output rxState_t    rxState
);

  rxState_t nextState;

  always_comb begin
    nextState = rxState;
    strobe    = '0;
    beatStore = 1'b0;
    if (pktStart) begin
      strobe.clearBytes = 1'b1;
      if (availZero) begin
        nextState        = ST_DROP;
        strobe.countDrop = 1'b1;
      end else begin
        nextState = ST_RECV;
      end
    end else begin
      unique case (rxState)
        ST_RECV: begin
          if (beatValid && availZero) begin
            strobe.latchErr = 1'b1;
            nextState       = pktEnd ? ST_IDLE : ST_DISCARD;
          end else begin
            if (beatValid) begin
              strobe.addBeat = 1'b1;
              beatStore      = 1'b1;
            end
            if (pktEnd) begin
              strobe.latchOk = 1'b1;
              nextState      = ST_IDLE;
            end
          end
        end
        ST_DISCARD, ST_DROP: begin
          if (pktEnd) nextState = ST_IDLE;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxState    <= ST_IDLE;
      pktDropIrq <= 1'b0;
    end else begin
      rxState    <= nextState;
      pktDropIrq <= pktStart && availZero;
    end
  end

  // R9: a discarded packet stays discarded until its end or a new start.
  p_discard_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (rxState == ST_DISCARD && !pktEnd && !pktStart) |=> (rxState == ST_DISCARD));

endmodule

// File: rtl/rx_dscr_tracker.sv
module rx_dscr_tracker
  import rdt_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BEAT_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [1:0]        rdAddr,
  output logic [DATA_W-1:0] rdData,
  input  logic              pktStart,
  input  logic              pktEnd,
  input  logic              beatValid,
  input  logic [BEAT_W-1:0] beatBytes,
  input  logic              dscrUsed,
  output logic              beatStore,
  output logic              watermarkLow,
  output logic              pktDropIrq
);

  ctrlStrobe_t strobe;
  logic        availZero;
  rxState_t    rxState;

  rdt_control u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .pktStart   (pktStart),
    .pktEnd     (pktEnd),
    .beatValid  (beatValid),
    .availZero  (availZero),
    .strobe     (strobe),
    .beatStore  (beatStore),
    .pktDropIrq (pktDropIrq),
    .rxState    (rxState)
  );

  rdt_datapath #(
    .DATA_W (DATA_W),
    .BEAT_W (BEAT_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .wrEn         (wrEn),
    .wrAddr       (wrAddr),
    .wrData       (wrData),
    .rdAddr       (rdAddr),
    .rdData       (rdData),
    .beatBytes    (beatBytes),
    .dscrUsed     (dscrUsed),
    .availZero    (availZero),
    .watermarkLow (watermarkLow)
  );

  // R5: a start with no descriptors raises the drop pulse next cycle.
  p_drop_irq_r5: assert property (@(posedge clk) disable iff (!rstN)
    (pktStart && availZero) |=> pktDropIrq);

  // R5: a dropped packet stores nothing.
  p_drop_nostore_r5: assert property (@(posedge clk) disable iff (!rstN)
    (rxState == ST_DROP) |-> !beatStore);

  // R10: a stored beat always has a descriptor behind it.
  p_store_needs_desc_r10: assert property (@(posedge clk) disable iff (!rstN)
    beatStore |-> !availZero);

endmodule

// File: tb/sim_rx_dscr_tracker.sv
`timescale 1ns/1ps
module sim_rx_dscr_tracker;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic [1:0]  rdAddr = '0;
  logic [15:0] rdData;
  logic        pktStart = 1'b0;
  logic        pktEnd = 1'b0;
  logic        beatValid = 1'b0;
  logic [3:0]  beatBytes = '0;
  logic        dscrUsed = 1'b0;
  logic        beatStore, watermarkLow, pktDropIrq;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // kinds: 0 register read, 1 watermarkLow, 2 beatStore, 3 pktDropIrq
  int    kindQ[$];
  int    addrQ[$];
  int    expQ[$];
  string tagQ[$];

  always #4 clk = ~clk;

  rx_dscr_tracker u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .pktStart(pktStart), .pktEnd(pktEnd),
    .beatValid(beatValid), .beatBytes(beatBytes), .dscrUsed(dscrUsed),
    .beatStore(beatStore), .watermarkLow(watermarkLow), .pktDropIrq(pktDropIrq)
  );

  task automatic push(input int kind, input int addr, input int expv, input string tag);
    kindQ.push_back(kind);
    addrQ.push_back(addr);
    expQ.push_back(expv);
    tagQ.push_back(tag);
  endtask

  task automatic expReg(input int addr, input int expv, input string tag);
    push(0, addr, expv, tag);
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wrReg(input logic [1:0] a, input logic [15:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    step();
    wrEn = 1'b0;
  endtask

  task automatic consume(input int n);
    for (int i = 0; i < n; i++) begin
      dscrUsed = 1'b1;
      step();
      dscrUsed = 1'b0;
    end
  endtask

  task automatic beat(input logic [3:0] b, input bit withEnd, input int expStore, input string tag);
    beatValid = 1'b1; beatBytes = b; pktEnd = withEnd;
    push(2, 0, expStore, tag);
    step();
    beatValid = 1'b0; pktEnd = 1'b0; beatBytes = '0;
  endtask

  task automatic startPkt();
    pktStart = 1'b1;
    step();
    pktStart = 1'b0;
  endtask

  task automatic endPkt();
    pktEnd = 1'b1;
    step();
    pktEnd = 1'b0;
  endtask

  // Monitor: pops expected items at each falling edge and compares.
  initial begin
    forever begin
      @(negedge clk);
      while (kindQ.size() != 0) begin
        int kind, addr, expv, act;
        string tag;
        kind = kindQ.pop_front();
        addr = addrQ.pop_front();
        expv = expQ.pop_front();
        tag  = tagQ.pop_front();
        case (kind)
          0: begin rdAddr = addr[1:0]; #0.2; act = int'(rdData); end
          1: act = int'(watermarkLow);
          2: act = int'(beatStore);
          default: act = int'(pktDropIrq);
        endcase
        checks++;
        if (act != expv) begin
          fails++;
          $display("FAIL %s kind=%0d addr=%0d actual=0x%0h expected=0x%0h", tag, kind, addr, act, expv);
        end
      end
    end
  end

  // Watchdog
  initial begin
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    // R1 reset state
    push(2, 0, 0, "R1 beatStore");
    expReg(0, 0, "R1 count");
    expReg(1, 0, "R1 thresh");
    expReg(2, 0, "R1 drop");
    expReg(3, 0, "R1 status");
    push(1, 0, 0, "R1 watermark");
    push(3, 0, 0, "R1 dropIrq");
    step();
    rstN = 1'b1;
    step();

    // R2 add, R4 threshold
    wrReg(2'd0, 16'd5);
    expReg(0, 5, "R2 add");
    wrReg(2'd1, 16'd3);
    expReg(1, 3, "R4 thresh readback");
    push(1, 0, 0, "R4 5<3 false");
    step();

    // R3 consume, R4 watermark rises then falls
    consume(3);
    expReg(0, 2, "R3 consume three");
    push(1, 0, 1, "R4 2<3 true");
    step();
    wrEn = 1'b1; wrAddr = 2'd0; wrData = 16'd4; dscrUsed = 1'b1;
    step();
    wrEn = 1'b0; dscrUsed = 1'b0;
    expReg(0, 5, "R3 write plus consume");
    push(1, 0, 0, "R4 watermark clears");
    step();

    // R11 status write ignored
    wrReg(2'd3, 16'hABCD);
    expReg(3, 0, "R11 status write ignored");
    step();

    // R10 beat outside a packet
    beat(4'd7, 1'b0, 0, "R10 beat outside packet");
    expReg(3, 0, "R10 status untouched");

    // R8 normal packet, beat on end counted
    startPkt();
    beat(4'd8, 1'b0, 1, "R8 beat stored");
    beat(4'd5, 1'b1, 1, "R8 end beat stored");
    expReg(3, 13, "R8 status bytes");
    expReg(0, 5, "R8 count untouched");
    step();

    // R3 consume at zero, R5 drop at start
    consume(5);
    expReg(0, 0, "R3 drained");
    step();
    consume(1);
    expReg(0, 0, "R3 consume at zero");
    startPkt();
    push(3, 0, 1, "R5 drop pulse");
    expReg(2, 1, "R6 drop counted");
    beat(4'd9, 1'b0, 0, "R5 no store in dropped packet");
    push(3, 0, 0, "R5 pulse one cycle");
    endPkt();
    startPkt();
    endPkt();
    expReg(2, 2, "R6 second drop");
    expReg(3, 13, "R5 status untouched");
    step();

    // R6 clear, and clear coinciding with a drop
    wrReg(2'd2, 16'h1234);
    expReg(2, 0, "R6 any write clears");
    step();
    wrEn = 1'b1; wrAddr = 2'd2; wrData = 16'h0; pktStart = 1'b1;
    step();
    wrEn = 1'b0; pktStart = 1'b0;
    expReg(2, 1, "R6 clear with drop gives one");
    endPkt();

    // R9 resume after drop
    wrReg(2'd0, 16'd2);
    startPkt();
    beat(4'd4, 1'b0, 1, "R9 store after refill");
    endPkt();
    expReg(3, 4, "R9 status after resume");
    step();

    // R7 mid-packet exhaustion, R9 discard persists through refill
    startPkt();
    beat(4'd6, 1'b0, 1, "R7 first beat stored");
    consume(2);
    beat(4'd3, 1'b0, 0, "R7 beat with no descriptor");
    expReg(3, 32'h8006, "R7 error status");
    wrReg(2'd0, 16'd3);
    beat(4'd7, 1'b0, 0, "R9 still discarding after refill");
    endPkt();
    expReg(3, 32'h8006, "R9 status kept");
    expReg(2, 1, "R7 error is not a drop");
    startPkt();
    beat(4'd2, 1'b0, 1, "R9 next packet stored");
    beat(4'd1, 1'b1, 1, "R9 end beat stored");
    expReg(3, 3, "R9 clean status");
    step();

    // R2 saturation, R4 threshold at max
    wrReg(2'd0, 16'hFFFF);
    expReg(0, 32'hFFFF, "R2 saturates");
    step();
    wrEn = 1'b1; wrAddr = 2'd0; wrData = 16'd1; dscrUsed = 1'b1;
    step();
    wrEn = 1'b0; dscrUsed = 1'b0;
    expReg(0, 32'hFFFF, "R3 saturated write plus consume");
    wrReg(2'd1, 16'hFFFF);
    push(1, 0, 0, "R4 equal is not below");
    step();
    consume(1);
    push(1, 0, 1, "R4 one below");
    expReg(0, 32'hFFFE, "R3 consume from max");
    step();
    step();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule